// File: doc/BRIEF.md
# Configuration Record Stream Loader

This block takes a stream of 16-bit words on a valid/ready input and fills a set of acquisition control registers from it. A frame opens with a 32-bit opening marker, carries any number of tagged records, and closes with a 32-bit closing marker. Each record is one header word followed by a payload. The header says which variable the record targets and how many payload words follow.

Known records load the mode word, the 32-bit clock divider, the 32-bit sample count, the 32-bit trigger position, the trigger global word and the channel-enable word. The trigger-table record is passed out word by word on a write port whose address counts up from zero. Records with an unknown tag are skipped by their length. A good closing marker raises a one-cycle done pulse. A bad one sets a sticky error flag. In both cases the loader goes back to hunting for the next opening marker.

Both 32-bit markers are a 16-bit word sent twice, so a frame with a header word equal to 0xFA5A cannot be sent: the loader reads that word as the first half of the closing marker. The word after a complete opening marker is always read as a header.

Top module: `cfg_tlv_loader`

## Requirements
- R1: After reset every register output, the table write strobe, the done pulse and the error flag are zero.
- R2: While hunting, words are discarded. Only two consecutive accepted words of 0xF5A5 start a frame. Records sent before that leave every register unchanged.
- R3: A header word holds the tag in bits [15:8] and the payload length in words in bits [7:0]. The tags are: mode 0, divider 1, count 3, trigger position 5, trigger global 7, channel enable 8. For the 32-bit fields, payload word 0 loads bits [15:0] and payload word 1 loads bits [31:16].
- R4: A record with any other tag (except the table tag 64) has all of its payload words consumed and dropped, even payload words equal to a marker. The record that follows it is decoded normally.
- R5: Each payload word of a table record (tag 64) gives one write pulse, one cycle after the word is accepted. The address counts from 0 in payload order. Only the first TBL_WORDS words are written.
- R6: In header position, two consecutive words of 0xFA5A close the frame. `cfg_done_o` is high for exactly the one cycle after the second word is accepted.
- R7: If the word after a 0xFA5A in header position is anything else, `sync_err_o` is set and stays set until reset. No done pulse is raised, and the loader returns to hunting.
- R8: `in_ready` is always high. Cycles with `in_valid` low do not advance parsing, so gaps between words do not change the result.
- R9: A header with length 0 has no payload. The next word is read as a header.
- R10: Payload words past the width of a register field are ignored. A divider record of length 1 replaces only bits [15:0]. A mode record of length 3 loads only its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_word | input | 16 | Input stream word |
| in_ready | output | 1 | Always ready |
| mode_o | output | 16 | Mode register |
| div_o | output | 32 | Clock divider |
| count_o | output | 32 | Sample count |
| tpos_o | output | 32 | Trigger position |
| tglb_o | output | 16 | Trigger global word |
| chen_o | output | 16 | Channel enable |
| tbl_we_o | output | 1 | Trigger-table write strobe |
| tbl_addr_o | output | AW | Trigger-table word address |
| tbl_data_o | output | 16 | Trigger-table write data |
| cfg_done_o | output | 1 | Frame closed correctly (one cycle) |
| sync_err_o | output | 1 | Sticky bad-closing-marker flag |

## Verification
A register loads at the clock edge that accepts its payload word, so its new value is visible at the following falling edge. The table strobe, address and data also appear in that one registered cycle, and the bench records them at falling edges only. The done pulse is due in the cycle after the second closing word is accepted. The bench reads it at the first falling edge after that word's edge, then again one cycle later to confirm it has dropped. Error and register checks wait until the stream has been driven and at least one idle cycle has passed.

// File: rtl/cfg_tlv_pkg.sv
package cfg_tlv_pkg;
  localparam logic [15:0] SYNC_OPEN_W  = 16'hF5A5;
  localparam logic [15:0] SYNC_CLOSE_W = 16'hFA5A;

  localparam logic [7:0] TAG_MODE  = 8'd0;
  localparam logic [7:0] TAG_DIV   = 8'd1;
  localparam logic [7:0] TAG_COUNT = 8'd3;
  localparam logic [7:0] TAG_TPOS  = 8'd5;
  localparam logic [7:0] TAG_TGLB  = 8'd7;
  localparam logic [7:0] TAG_CHEN  = 8'd8;
  localparam logic [7:0] TAG_TABLE = 8'd64;

  typedef enum logic [2:0] {
    ST_HUNT_LO, ST_HUNT_HI, ST_HEADER, ST_PAYLOAD, ST_CLOSE
  } parse_st_t;

  function automatic logic [7:0] hdr_tag(input logic [15:0] w);
    return w[15:8];
  endfunction

  function automatic logic [7:0] hdr_len(input logic [15:0] w);
    return w[7:0];
  endfunction

  // Replace one 16-bit half of a 32-bit field (little-endian word order)
  function automatic logic [31:0] put_half(input logic [31:0] old,
                                           input logic [15:0] w,
                                           input logic upper);
    return upper ? {w, old[15:0]} : {old[31:16], w};
  endfunction
endpackage

// File: rtl/cfg_word_match.sv
module cfg_word_match
  import cfg_tlv_pkg::*;
(
  input  logic [15:0] word,
  output logic        is_open,
  output logic        is_close
);
  assign is_open  = (word == SYNC_OPEN_W);
  assign is_close = (word == SYNC_CLOSE_W);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_tlv_pkg::*;
#(
  parameter int TBL_WORDS = 160,
  parameter int AW        = $clog2(TBL_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_tag,
  input  logic [7:0]    wr_idx,
  input  logic [15:0]   wr_word,
  output logic [15:0]   mode_o,
  output logic [31:0]   div_o,
  output logic [31:0]   count_o,
  output logic [31:0]   tpos_o,
  output logic [15:0]   tglb_o,
  output logic [15:0]   chen_o,
  output logic          tbl_we_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic [15:0]   tbl_data_o
);
  localparam logic [8:0] TBL_LIM = 9'(TBL_WORDS);

  logic in_field32;
  logic in_table;
  assign in_field32 = (wr_idx < 8'd2);
  assign in_table   = ({1'b0, wr_idx} < TBL_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= '0;
      div_o      <= '0;
      count_o    <= '0;
      tpos_o     <= '0;
      tglb_o     <= '0;
      chen_o     <= '0;
      tbl_we_o   <= 1'b0;
      tbl_addr_o <= '0;
      tbl_data_o <= '0;
    end else begin
      tbl_we_o <= 1'b0;
      if (wr_en) begin
        case (wr_tag)
          TAG_MODE:  if (wr_idx == 8'd0) mode_o <= wr_word;
          TAG_DIV:   if (in_field32) div_o   <= put_half(div_o,   wr_word, wr_idx[0]);
          TAG_COUNT: if (in_field32) count_o <= put_half(count_o, wr_word, wr_idx[0]);
          TAG_TPOS:  if (in_field32) tpos_o  <= put_half(tpos_o,  wr_word, wr_idx[0]);
          TAG_TGLB:  if (wr_idx == 8'd0) tglb_o <= wr_word;
          TAG_CHEN:  if (wr_idx == 8'd0) chen_o <= wr_word;
          TAG_TABLE: if (in_table) begin
            tbl_we_o   <= 1'b1;
            tbl_addr_o <= wr_idx[AW-1:0];
            tbl_data_o <= wr_word;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  tbl_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_we_o && $past(tbl_we_o)) |-> (tbl_addr_o == $past(tbl_addr_o) + 1'b1));

  // R5
  tbl_range_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_we_o |-> ({1'b0, tbl_addr_o} < (AW+1)'(TBL_WORDS)));
endmodule

// File: rtl/cfg_tlv_loader.sv
module cfg_tlv_loader
  import cfg_tlv_pkg::*;
#(
  parameter int TBL_WORDS = 160,
  parameter int AW        = $clog2(TBL_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [15:0]   in_word,
  output logic          in_ready,
  output logic [15:0]   mode_o,
  output logic [31:0]   div_o,
  output logic [31:0]   count_o,
  output logic [31:0]   tpos_o,
  output logic [15:0]   tglb_o,
  output logic [15:0]   chen_o,
  output logic          tbl_we_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic [15:0]   tbl_data_o,
  output logic          cfg_done_o,
  output logic          sync_err_o
);
  parse_st_t  state_q;
  logic [7:0] tag_q, rem_q, idx_q;
  logic       accept, is_open, is_close;
  logic       payload_wr, hdr_taken, close_ok, close_bad;

  assign in_ready = 1'b1;
  assign accept   = in_valid;

  cfg_word_match u_match (
    .word     (in_word),
    .is_open  (is_open),
    .is_close (is_close)
  );

  // Named events used by the FSM and by the assertions
  assign payload_wr = accept && (state_q == ST_PAYLOAD);
  assign hdr_taken  = accept && (state_q == ST_HEADER) && !is_close;
  assign close_ok   = accept && (state_q == ST_CLOSE) && is_close;
  assign close_bad  = accept && (state_q == ST_CLOSE) && !is_close;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT_LO;
      tag_q      <= '0;
      rem_q      <= '0;
      idx_q      <= '0;
      cfg_done_o <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      cfg_done_o <= close_ok;
      if (close_bad) sync_err_o <= 1'b1;
      if (accept) begin
        case (state_q)
          ST_HUNT_LO: if (is_open) state_q <= ST_HUNT_HI;
          ST_HUNT_HI: state_q <= is_open ? ST_HEADER : ST_HUNT_LO;
          ST_HEADER: begin
            if (is_close) begin
              state_q <= ST_CLOSE;
            end else begin
              tag_q   <= hdr_tag(in_word);
              rem_q   <= hdr_len(in_word);
              idx_q   <= '0;
              state_q <= (hdr_len(in_word) == 8'd0) ? ST_HEADER : ST_PAYLOAD;
            end
          end
          ST_PAYLOAD: begin
            idx_q <= idx_q + 8'd1;
            rem_q <= rem_q - 8'd1;
            if (rem_q == 8'd1) state_q <= ST_HEADER;
          end
          ST_CLOSE: state_q <= ST_HUNT_LO;
          default:  state_q <= ST_HUNT_LO;
        endcase
      end
    end
  end

  cfg_reg_bank #(.TBL_WORDS(TBL_WORDS), .AW(AW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (payload_wr),
    .wr_tag     (tag_q),
    .wr_idx     (idx_q),
    .wr_word    (in_word),
    .mode_o     (mode_o),
    .div_o      (div_o),
    .count_o    (count_o),
    .tpos_o     (tpos_o),
    .tglb_o     (tglb_o),
    .chen_o     (chen_o),
    .tbl_we_o   (tbl_we_o),
    .tbl_addr_o (tbl_addr_o),
    .tbl_data_o (tbl_data_o)
  );

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done_o |=> !cfg_done_o);

  // R6
  done_follows_close_chk: assert property (@(posedge clk) disable iff (rst)
    close_ok |=> cfg_done_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err_o |=> sync_err_o);

  // R2
  hunt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HUNT_LO || state_q == ST_HUNT_HI) |=> !tbl_we_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_q));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr_taken && in_word[7:0] == 8'd0) |=> (state_q == ST_HEADER));
endmodule

// File: tb/cfg_tlv_loader_tb.sv
module cfg_tlv_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TBL = 160;
  localparam int AW = $clog2(TBL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic in_ready;
  logic [15:0] mode_o, tglb_o, chen_o, tbl_data_o;
  logic [31:0] div_o, count_o, tpos_o;
  logic tbl_we_o, cfg_done_o, sync_err_o;
  logic [AW-1:0] tbl_addr_o;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, order_bad = 0, next_addr = 0;
  logic [15:0] shadow [TBL];
  logic gap_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_tlv_loader #(.TBL_WORDS(TBL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .mode_o(mode_o), .div_o(div_o), .count_o(count_o),
    .tpos_o(tpos_o), .tglb_o(tglb_o), .chen_o(chen_o), .tbl_we_o(tbl_we_o),
    .tbl_addr_o(tbl_addr_o), .tbl_data_o(tbl_data_o),
    .cfg_done_o(cfg_done_o), .sync_err_o(sync_err_o)
  );

  // Table port recorder, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && tbl_we_o) begin
      if (int'(tbl_addr_o) != next_addr) order_bad++;
      if (int'(tbl_addr_o) < TBL) shadow[tbl_addr_o] = tbl_data_o;
      next_addr = int'(tbl_addr_o) + 1;
      wr_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    if (gap_mode) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 16'hF5A5;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 16'h0;
  endtask

  task automatic open_frame();
    push(16'hF5A5); push(16'hF5A5);
  endtask

  // Close the frame and check the one-cycle done pulse (R6)
  task automatic close_frame(input logic expect_done);
    push(16'hFA5A); push(16'hFA5A);
    idle();
    check("R6 done pulse", {31'b0, cfg_done_o}, {31'b0, expect_done});
    idle();
    check("R6 done drops", {31'b0, cfg_done_o}, 32'h0);
  endtask

  task automatic rec16(input logic [7:0] tag, input logic [15:0] v);
    push({tag, 8'd1}); push(v);
  endtask

  task automatic rec32(input logic [7:0] tag, input logic [31:0] v);
    push({tag, 8'd2}); push(v[15:0]); push(v[31:16]);
  endtask

  function automatic logic [31:0] pat(input int v, input int k);
    return (32'h9E37_79B9 * (v + 1)) ^ (32'h0101_0101 << k) ^ 32'(k * 77);
  endfunction

  initial begin
    int bad;
    logic [31:0] old_div;
    for (int i = 0; i < TBL; i++) shadow[i] = 16'hxxxx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", {16'b0, mode_o}, 0);
    check("R1 div", div_o, 0);
    check("R1 count", count_o, 0);
    check("R1 tpos", tpos_o, 0);
    check("R1 tglb/chen", {tglb_o, chen_o}, 0);
    check("R1 flags", {29'b0, tbl_we_o, cfg_done_o, sync_err_o}, 0);
    check("R8 ready", {31'b0, in_ready}, 1);

    // R2: records before sync, and a broken sync, are discarded
    rec16(8'd0, 16'hBEEF);
    push(16'hF5A5); push(16'h1234); rec16(8'd0, 16'hCAFE);
    idle(); idle();
    check("R2 pre-sync ignored", {16'b0, mode_o}, 0);

    // R3 sweep over all known fields with computed values
    for (int v = 0; v < 8; v++) begin
      open_frame();
      rec16(8'd0, pat(v,0)[15:0]);
      rec32(8'd1, pat(v,1));
      rec32(8'd3, pat(v,2));
      rec32(8'd5, pat(v,3));
      rec16(8'd7, pat(v,4)[15:0]);
      rec16(8'd8, pat(v,5)[15:0]);
      close_frame(1'b1);
      check("R3 mode", {16'b0, mode_o}, {16'b0, pat(v,0)[15:0]});
      check("R3 div", div_o, pat(v,1));
      check("R3 count", count_o, pat(v,2));
      check("R3 tpos", tpos_o, pat(v,3));
      check("R3 tglb", {16'b0, tglb_o}, {16'b0, pat(v,4)[15:0]});
      check("R3 chen", {16'b0, chen_o}, {16'b0, pat(v,5)[15:0]});
    end

    // R4 unknown tags skipped, payload mimicking markers; R9 zero length
    open_frame();
    push(16'h0204); push(16'hF5A5); push(16'hFA5A); push(16'hFA5A); push(16'h0001);
    push(16'h0900);
    rec16(8'd0, 16'h1111);
    close_frame(1'b1);
    check("R4 skip then mode", {16'b0, mode_o}, 32'h1111);
    open_frame();
    push(16'h2000);
    rec16(8'd8, 16'h00F3);
    close_frame(1'b1);
    check("R9 zero-length then chen", {16'b0, chen_o}, 32'h00F3);

    // R10 short and long payloads
    old_div = div_o;
    open_frame();
    push(16'h0003); push(16'h4321); push(16'hFFFF); push(16'hEEEE);
    push(16'h0101); push(16'h7777);
    push(16'h0303); push(16'hAAAA); push(16'hBBBB); push(16'hCCCC);
    close_frame(1'b1);
    check("R10 mode long", {16'b0, mode_o}, 32'h4321);
    check("R10 div short", div_o, {old_div[31:16], 16'h7777});
    check("R10 count long", count_o, 32'hBBBB_AAAA);

    // R5 full table sweep
    wr_cnt = 0; next_addr = 0; order_bad = 0;
    open_frame();
    push({8'd64, 8'(TBL)});
    for (int i = 0; i < TBL; i++) push(16'(i * 16'h0123) ^ 16'hA5C3);
    close_frame(1'b1);
    check("R5 table count", wr_cnt, TBL);
    check("R5 table order", order_bad, 0);
    bad = 0;
    for (int i = 0; i < TBL; i++)
      if (shadow[i] !== (16'(i * 16'h0123) ^ 16'hA5C3)) bad++;
    check("R5 table data", bad, 0);

    // R5 overlong table record: only TBL writes; short record from 0
    wr_cnt = 0; next_addr = 0; order_bad = 0;
    open_frame();
    push({8'd64, 8'(TBL + 2)});
    for (int i = 0; i < TBL + 2; i++) push(16'(i) ^ 16'h5A00);
    next_addr = 0;
    close_frame(1'b1);
    check("R5 overlong count", wr_cnt, TBL);
    wr_cnt = 0; next_addr = 0; order_bad = 0;
    open_frame();
    push(16'h4003); push(16'h0AAA); push(16'h0BBB); push(16'h0CCC);
    close_frame(1'b1);
    check("R5 short count", wr_cnt, 3);
    check("R5 short order", order_bad, 0);
    check("R5 short data", {shadow[0], shadow[2]}, {16'h0AAA, 16'h0CCC});

    // R8 gaps between words give the same result
    gap_mode = 1'b1;
    open_frame();
    rec32(8'd5, 32'h0012_3456);
    rec16(8'd7, 16'h0E21);
    gap_mode = 1'b0;
    close_frame(1'b1);
    check("R8 gapped tpos", tpos_o, 32'h0012_3456);
    check("R8 gapped tglb", {16'b0, tglb_o}, 32'h0E21);

    // R7 bad closing marker
    check("R7 err clear before", {31'b0, sync_err_o}, 0);
    open_frame();
    rec16(8'd0, 16'h2222);
    push(16'hFA5A); push(16'h1234);
    idle();
    check("R7 no done", {31'b0, cfg_done_o}, 0);
    check("R7 err set", {31'b0, sync_err_o}, 1);
    rec16(8'd0, 16'h3333);
    idle(); idle();
    check("R7 back to hunt", {16'b0, mode_o}, 32'h2222);
    open_frame();
    rec16(8'd0, 16'h4444);
    close_frame(1'b1);
    check("R7 err sticky", {31'b0, sync_err_o}, 1);
    check("R7 recovers", {16'b0, mode_o}, 32'h4444);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule